// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the bus-facing controller of a 2 KB serial EEPROM on a two-wire bus. It oversamples the clock and data lines with the system clock and recognises Start, repeated Start and Stop conditions. It shifts in the control byte and the word address and acknowledges by pulling the data line low through an open-drain enable. It also sends read data most-significant bit first. The block keeps one address pointer that serves writes, current-address reads, random reads and sequential reads.

Write data goes out one byte at a time to an external page buffer together with its full address. When a Stop closes a write that carried data, a commit pulse tells the buffer to start the internal programming cycle. A busy input from the programming logic makes the engine refuse its control byte, so a host can poll for the end of a write by repeating the control byte. Reads use a synchronous memory port whose data returns one clock after the request.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A Start is a falling data line while the clock line is high. A Start seen in any state, including part-way through a byte, begins the reception of a new control byte.
- R2: The control byte arrives most-significant bit first. Bits 7:4 are the device code 1010, bits 3:1 are the block select and bit 0 is the direction (0 write, 1 read). If the device code is anything else, the byte gets no acknowledge and the engine ignores the bus until the next Start.
- R3: For each accepted byte the engine pulls the data line low during the ninth clock. `sda_pull_o` is low out of reset and changes only after a falling clock edge, never while the clock line stays high.
- R4: If `busy_i` is high when the control byte completes, the byte gets no acknowledge. The same byte is acknowledged once `busy_i` is low.
- R5: In a write, the byte after the control byte sets the pointer to {block select, word address}. Each later byte produces one `pg_wr_o` pulse carrying the pointer and the byte, and then the pointer advances by one.
- R6: `pg_commit_o` pulses once on a Stop that ends a write which delivered at least one data byte. A repeated Start, or a write that carried only an address, produces no commit.
- R7: A current-address read returns the byte at the address after the last one accessed, whether that access was a read or a write.
- R8: A write header carrying a word address, then a repeated Start and a read control byte, returns the byte at that address.
- R9: A master acknowledge after a read byte fetches and sends the next address, and the pointer wraps from 7FF to 000. A master non-acknowledge stops any further fetch.
- R10: Each read byte is fetched with one `mem_rd_o` pulse carrying `mem_addr_o`. The data taken from `mem_data_i` one clock later is shifted out most-significant bit first, and a write and a read fetch never happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| busy_i | input | 1 | Internal programming cycle running |
| mem_data_i | input | 8 | Read data, valid one clock after `mem_rd_o` |
| sda_pull_o | output | 1 | Pull the data line low (open-drain enable) |
| pg_wr_o | output | 1 | One-cycle strobe: a write byte is on `pg_addr_o`/`pg_data_o` |
| pg_addr_o | output | 11 | Full address of the write byte |
| pg_data_o | output | 8 | Write byte |
| pg_commit_o | output | 1 | One-cycle strobe: start programming the buffered bytes |
| mem_rd_o | output | 1 | One-cycle read request |
| mem_addr_o | output | 11 | Read address |

## Verification
Two functions can fall on the same bus event. The write that ends with a repeated Start has to load the pointer without committing, and the next read control byte has to fetch from that pointer. The bench provokes this with a random read whose word address sits two bytes below the top of the array, followed by a sequential read across the 7FF-to-000 wrap. It judges the case by the fetch addresses seen on the read port against its own pointer model and by a commit count that does not change. The second pair is acknowledge polling against the commit: a control byte is sent straight after the Stop that raised the commit, while the bench's page buffer still holds busy high. The bench expects no acknowledge there, and expects one for the same byte once busy has dropped.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CTRL,
      ST_CTRL_ACK,
      ST_WADDR,
      ST_WADDR_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RACK
   } ee_state_t;

   localparam logic [3:0] EE_DEV_CODE = 4'b1010;
   localparam int         EE_BYTE_W   = 8;

endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
   parameter int   STAGES = 2,
   parameter logic INIT   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 1) begin : g_bad_depth
         $error("i2c_ee_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= INIT;
            else        chain <= d;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{INIT}};
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/i2c_ee_cond.sv
module i2c_ee_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_p;
   logic sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_rise  =  scl_s & ~scl_p;
   assign scl_fall  = ~scl_s &  scl_p;
   assign start_det =  scl_s &  scl_p &  sda_p & ~sda_s;
   assign stop_det  =  scl_s &  scl_p & ~sda_p &  sda_s;

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
   import i2c_ee_pkg::*;
#(
   parameter int         ADDR_W      = 11,
   parameter logic [3:0] DEV_CODE    = EE_DEV_CODE,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              busy_i,
   input  logic [7:0]        mem_data_i,
   output logic              sda_pull_o,
   output logic              pg_wr_o,
   output logic [ADDR_W-1:0] pg_addr_o,
   output logic [7:0]        pg_data_o,
   output logic              pg_commit_o,
   output logic              mem_rd_o,
   output logic [ADDR_W-1:0] mem_addr_o
);

   localparam int BLK_W = ADDR_W - EE_BYTE_W;

   generate
      if (ADDR_W < 9 || ADDR_W > 11) begin : g_bad_addr
         $error("i2c_eeprom_slave: ADDR_W must lie in 9..11");
      end
   endgenerate

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_det, stop_det;

   i2c_ee_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
   i2c_ee_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

   i2c_ee_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   ee_state_t         st;
   logic [3:0]        bitcnt;
   logic [7:0]        rx, tx;
   logic [BLK_W-1:0]  blk;
   logic [ADDR_W-1:0] ptr_q;
   logic              rnw, wrote, tx_ld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         bitcnt      <= '0;
         rx          <= '0;
         tx          <= '0;
         blk         <= '0;
         ptr_q       <= '0;
         rnw         <= 1'b0;
         wrote       <= 1'b0;
         tx_ld       <= 1'b0;
         sda_pull_o  <= 1'b0;
         pg_wr_o     <= 1'b0;
         pg_addr_o   <= '0;
         pg_data_o   <= '0;
         pg_commit_o <= 1'b0;
         mem_rd_o    <= 1'b0;
         mem_addr_o  <= '0;
      end else begin
         pg_wr_o     <= 1'b0;
         pg_commit_o <= 1'b0;
         mem_rd_o    <= 1'b0;
         // read data returns one clock after the request is seen
         tx_ld       <= mem_rd_o;
         if (tx_ld) tx <= mem_data_i;

         if (stop_det) begin
            sda_pull_o  <= 1'b0;
            st          <= ST_IDLE;
            pg_commit_o <= wrote;
            wrote       <= 1'b0;
         end else if (start_det) begin
            sda_pull_o <= 1'b0;
            st         <= ST_CTRL;
            bitcnt     <= '0;
            wrote      <= 1'b0;
         end else if (scl_rise) begin
            unique case (st)
               ST_CTRL, ST_WADDR, ST_WDATA: begin
                  rx     <= {rx[6:0], sda_s};
                  bitcnt <= bitcnt + 4'd1;
               end
               ST_RDATA: bitcnt <= bitcnt + 4'd1;
               ST_RACK: begin
                  if (!sda_s) begin
                     mem_rd_o   <= 1'b1;
                     mem_addr_o <= ptr_q;
                     ptr_q      <= ptr_q + 1'b1;
                     st         <= ST_RDATA;
                     bitcnt     <= '0;
                  end else begin
                     st <= ST_IDLE;
                  end
               end
               default: ;
            endcase
         end else if (scl_fall) begin
            unique case (st)
               ST_CTRL: if (bitcnt == 4'd8) begin
                  if (rx[7:4] == DEV_CODE && !busy_i) begin
                     sda_pull_o <= 1'b1;
                     st         <= ST_CTRL_ACK;
                     blk        <= rx[BLK_W:1];
                     rnw        <= rx[0];
                     if (rx[0]) begin
                        mem_rd_o   <= 1'b1;
                        mem_addr_o <= ptr_q;
                        ptr_q      <= ptr_q + 1'b1;
                     end
                  end else begin
                     st <= ST_IDLE;
                  end
               end
               ST_CTRL_ACK: begin
                  bitcnt <= '0;
                  if (rnw) begin
                     sda_pull_o <= ~tx[7];
                     st         <= ST_RDATA;
                  end else begin
                     sda_pull_o <= 1'b0;
                     st         <= ST_WADDR;
                  end
               end
               ST_WADDR: if (bitcnt == 4'd8) begin
                  sda_pull_o <= 1'b1;
                  ptr_q      <= {blk, rx};
                  st         <= ST_WADDR_ACK;
               end
               ST_WDATA: if (bitcnt == 4'd8) begin
                  sda_pull_o <= 1'b1;
                  pg_wr_o    <= 1'b1;
                  pg_addr_o  <= ptr_q;
                  pg_data_o  <= rx;
                  ptr_q      <= ptr_q + 1'b1;
                  wrote      <= 1'b1;
                  st         <= ST_WDATA_ACK;
               end
               ST_WADDR_ACK, ST_WDATA_ACK: begin
                  sda_pull_o <= 1'b0;
                  st         <= ST_WDATA;
                  bitcnt     <= '0;
               end
               ST_RDATA: begin
                  if (bitcnt == 4'd8) begin
                     sda_pull_o <= 1'b0;
                     st         <= ST_RACK;
                  end else begin
                     sda_pull_o <= ~tx[3'd7 - bitcnt[2:0]];
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/i2c_ee_chk.sv
module i2c_ee_chk #(
   parameter int ADDR_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_s,
   input logic              scl_fall,
   input logic              stop_det,
   input logic              sda_pull_o,
   input logic              pg_wr_o,
   input logic [ADDR_W-1:0] pg_addr_o,
   input logic              pg_commit_o,
   input logic              mem_rd_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic [ADDR_W-1:0] ptr_q
);

   p_pull_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull_o) |-> $past(scl_fall));

   p_pull_hold_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s)) |-> $stable(sda_pull_o));

   p_commit_on_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pg_commit_o |-> $past(stop_det));

   p_write_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pg_wr_o |-> (ptr_q == ADDR_W'(pg_addr_o + 1'b1)));

   p_read_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_o |-> (ptr_q == ADDR_W'(mem_addr_o + 1'b1)));

   p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(pg_wr_o && mem_rd_o));

endmodule

bind i2c_eeprom_slave i2c_ee_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall),
   .stop_det(stop_det), .sda_pull_o(sda_pull_o), .pg_wr_o(pg_wr_o),
   .pg_addr_o(pg_addr_o), .pg_commit_o(pg_commit_o), .mem_rd_o(mem_rd_o),
   .mem_addr_o(mem_addr_o), .ptr_q(ptr_q));

// File: tb/sim_i2c_eeprom_slave.sv
module sim_i2c_eeprom_slave;

   localparam int CLK_PERIOD = 10;
   localparam int HP         = 8;
   localparam int BUSY_CLKS  = 600;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m_scl = 1'b1;
   logic        m_sda = 1'b1;
   logic        busy;
   logic [7:0]  mem_q;
   logic        sda_pull, pg_wr, pg_commit, mem_rd;
   logic [10:0] pg_addr, mem_addr;
   logic [7:0]  pg_data;
   logic        sda_bus;

   always #(CLK_PERIOD/2) clk = ~clk;
   assign sda_bus = m_sda & ~sda_pull;

   i2c_eeprom_slave u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .busy_i(busy),
      .mem_data_i(mem_q), .sda_pull_o(sda_pull), .pg_wr_o(pg_wr),
      .pg_addr_o(pg_addr), .pg_data_o(pg_data), .pg_commit_o(pg_commit),
      .mem_rd_o(mem_rd), .mem_addr_o(mem_addr));

   // ---- reference model state, owned by the monitor ----
   logic [7:0]  mem [0:2047];
   int          exp_ptr, seen_gen, rd_idx, busy_cnt, commits, reads;
   int          m_chk, m_bad, hold_viol;
   logic        prev_scl, prev_pull;
   int          pend_a [$];
   int          pend_d [$];
   // ---- written by the stimulus ----
   int          base_ptr, base_gen, push_idx;
   int          exp_data [0:63];
   int          n_chk, n_bad;

   function automatic logic [7:0] init_val(int a);
      return 8'((a * 7 + 3) ^ (a >> 3));
   endfunction

   assign busy = (busy_cnt > 0);

   always @(posedge clk) if (mem_rd) mem_q <= mem[mem_addr];

   always @(negedge clk) begin
      if (!rst_n) begin
         for (int a = 0; a < 2048; a++) mem[a] = init_val(a);
         exp_ptr = 0; seen_gen = 0; rd_idx = 0; busy_cnt = 0; commits = 0;
         reads = 0; m_chk = 0; m_bad = 0; hold_viol = 0;
         prev_scl = 1'b1; prev_pull = 1'b0;
      end else begin
         if (seen_gen != base_gen) begin
            exp_ptr  = base_ptr;
            seen_gen = base_gen;
         end
         if (busy_cnt > 0) busy_cnt--;
         if (pg_wr) begin
            m_chk++;
            if (pg_addr !== 11'(exp_ptr) || pg_data !== 8'(exp_data[rd_idx])) begin
               m_bad++;
               $display("FAIL R5 write strobe act=%h/%h exp=%h/%h",
                        pg_addr, pg_data, 11'(exp_ptr), 8'(exp_data[rd_idx]));
            end
            pend_a.push_back(int'(pg_addr));
            pend_d.push_back(int'(pg_data));
            rd_idx++;
            exp_ptr = (exp_ptr + 1) % 2048;
         end
         if (mem_rd) begin
            m_chk++;
            reads++;
            if (mem_addr !== 11'(exp_ptr)) begin
               m_bad++;
               $display("FAIL R10 fetch address act=%h exp=%h", mem_addr, 11'(exp_ptr));
            end
            exp_ptr = (exp_ptr + 1) % 2048;
         end
         if (pg_commit) begin
            commits++;
            while (pend_a.size() > 0) begin
               mem[pend_a.pop_front()] = 8'(pend_d.pop_front());
            end
            busy_cnt = BUSY_CLKS;
         end
         // R3: the pull enable must not move while the bus clock stays high
         if (m_scl && prev_scl && (sda_pull !== prev_pull)) hold_viol++;
         prev_scl  = m_scl;
         prev_pull = sda_pull;
      end
   end

   // ---- stimulus ----
   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic bus_start();
      m_sda = 1'b1; hold(HP);
      m_scl = 1'b1; hold(HP);
      m_sda = 1'b0; hold(HP);
      m_scl = 1'b0; hold(2);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; hold(HP);
      m_scl = 1'b1; hold(HP);
      m_sda = 1'b1; hold(HP);
   endtask

   task automatic send(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; hold(HP);
         m_scl = 1'b1; hold(HP);
         m_scl = 1'b0; hold(2);
      end
      m_sda = 1'b1; hold(HP);
      m_scl = 1'b1; hold(HP/2);
      ack = ~sda_bus;
      hold(HP/2);
      m_scl = 1'b0; hold(2);
   endtask

   task automatic recv(input logic ack_m, output logic [7:0] b);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         hold(HP);
         m_scl = 1'b1; hold(HP/2);
         b[i] = sda_bus;
         hold(HP/2);
         m_scl = 1'b0; hold(2);
      end
      m_sda = ~ack_m; hold(HP);
      m_scl = 1'b1; hold(HP);
      m_scl = 1'b0; hold(2);
      m_sda = 1'b1;
   endtask

   task automatic set_ptr(input int a);
      base_ptr = a;
      base_gen++;
   endtask

   task automatic expect_data(input logic [7:0] d);
      exp_data[push_idx] = int'(d);
      push_idx++;
   endtask

   task automatic wait_idle();
      while (busy) hold(1);
      hold(4);
   endtask

   initial begin
      logic       ack;
      logic [7:0] d;
      int         c0, r0;
      n_chk = 0; n_bad = 0; base_ptr = 0; base_gen = 0; push_idx = 0;
      hold(6);
      rst_n = 1'b1;
      hold(4);

      // reset state
      check("R3 pull idle after reset", 32'(sda_pull), 0);
      check("R6 no commit after reset", 32'(pg_commit), 0);
      check("R10 no fetch after reset", 32'(mem_rd), 0);

      // foreign device code
      r0 = reads;
      bus_start(); send(8'h62, ack); bus_stop();
      check("R2 foreign code no ack", 32'(ack), 0);
      check("R2 foreign code no fetch", 32'(reads - r0), 0);

      // single byte write at block 5, word 3C
      bus_start(); send(8'hAA, ack);
      check("R2 write control ack", 32'(ack), 1);
      send(8'h3C, ack); set_ptr(11'h53C);
      check("R5 word address ack", 32'(ack), 1);
      expect_data(8'h5A); send(8'h5A, ack);
      check("R3 data byte ack", 32'(ack), 1);
      bus_stop(); hold(4);
      check("R6 commit after write stop", 32'(commits), 1);

      // polling while the programming cycle runs
      bus_start(); send(8'hA0, ack); bus_stop();
      check("R4 no ack while busy", 32'(ack), 0);
      wait_idle();
      bus_start(); send(8'hA0, ack); bus_stop();
      check("R4 ack once idle", 32'(ack), 1);
      check("R6 address-less write no commit", 32'(commits), 1);

      // current-address reads after a write and after a read
      bus_start(); send(8'hA1, ack); recv(1'b0, d); bus_stop();
      check("R7 read control ack", 32'(ack), 1);
      check("R7 current read after write", 32'(d), 32'(mem[11'h53D]));
      bus_start(); send(8'hA1, ack); recv(1'b0, d); bus_stop();
      check("R7 current read after read", 32'(d), 32'(mem[11'h53E]));

      // random read near the top, sequential across the wrap
      c0 = commits; r0 = reads;
      bus_start(); send(8'hAE, ack); send(8'hFE, ack); set_ptr(11'h7FE);
      bus_start(); send(8'hA1, ack);
      check("R1 repeated start accepted", 32'(ack), 1);
      recv(1'b1, d);
      check("R8 random read 7FE", 32'(d), 32'(mem[11'h7FE]));
      recv(1'b1, d);
      check("R9 sequential read 7FF", 32'(d), 32'(mem[11'h7FF]));
      recv(1'b0, d);
      check("R9 wrap to 000", 32'(d), 32'(mem[0]));
      bus_stop(); hold(4);
      check("R9 nack ends fetching", 32'(reads - r0), 3);
      check("R6 repeated start no commit", 32'(commits - c0), 0);

      // page write of three bytes in block 1
      bus_start(); send(8'hA2, ack); send(8'h10, ack); set_ptr(11'h110);
      expect_data(8'h11); send(8'h11, ack);
      expect_data(8'h22); send(8'h22, ack);
      expect_data(8'h33); send(8'h33, ack);
      bus_stop(); hold(4);
      check("R6 commit after page write", 32'(commits - c0), 1);
      wait_idle();
      bus_start(); send(8'hA2, ack); send(8'h11, ack); set_ptr(11'h111);
      bus_start(); send(8'hA3, ack);
      recv(1'b1, d);
      check("R10 msb-first read of written 22", 32'(d), 32'h22);
      recv(1'b0, d);
      check("R5 second page byte 33", 32'(d), 32'h33);
      bus_stop();

      // start in the middle of a byte abandons it
      bus_start();
      for (int i = 0; i < 3; i++) begin
         m_sda = i[0]; hold(HP); m_scl = 1'b1; hold(HP); m_scl = 1'b0; hold(2);
      end
      bus_start(); send(8'hA1, ack);
      check("R1 start mid-byte restarts", 32'(ack), 1);
      recv(1'b0, d);
      check("R7 current read after sequence", 32'(d), 32'(mem[11'h113]));
      bus_stop(); hold(8);

      check("R3 pull stable while clock high", 32'(hold_viol), 0);

      $display("test done: total=%0d bad=%0d", n_chk + m_chk, n_bad + m_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", n_chk + m_chk + 1, n_bad + m_bad + 1);
      $finish;
   end

endmodule